// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block decides which power state a processor core sits in and turns that state into clock-enable and qualifier signals for the rest of the core. There are four states: Normal (everything clocked), Stop-Grant (core units halted, bus-interface and interrupt-controller logic still clocked), Sleep (only the PLL kept running) and Deep Sleep (nothing enabled). Platform logic moves the core between these states with three active-low request pins: stop-clock, sleep and deep-sleep. A level input reports whether the bus clock is present.

All request pins and the bus-clock-present input may change at any time relative to `clk_i`. Each one goes through a synchronizer of `SYNC_STAGES` flops before the state register sees it. The enables and qualifiers are decoded straight from the state register. When the core drops from Normal into Stop-Grant, the block raises a one-cycle request so that the bus unit can issue the Stop-Grant acknowledge transaction. All pins are plain levels, apart from that pulse. No data stream passes through the block, so no port carries a valid/ready handshake.

Top module: `pwr_state_seq`

## Requirements
- R1: While `rst_ni` is low, `pstate_o` is 0 (Normal), all four clock enables and both qualifiers are high, and `sg_ack_req_o` is low.
- R2: In Normal, a low `stop_req_ni` moves the block to Stop-Grant (code 1). `sg_ack_req_o` is high for exactly the first cycle of that state. Stop-Grant entered from any other state gives no pulse.
- R3: In Stop-Grant, `core_clk_en_o` is low and `bus_clk_en_o`, `intc_clk_en_o`, `pll_en_o`, `snoop_en_o` and `irq_en_o` are high.
- R4: In Stop-Grant, a high `stop_req_ni` returns the block to Normal with every output high. This wins over a sleep request seen in the same cycle.
- R5: A low `sleep_req_ni` has no effect in Normal. Normal can only be left for Stop-Grant.
- R6: In Stop-Grant, with `stop_req_ni` still low, a low `sleep_req_ni` moves the block to Sleep (code 2). In Sleep only `pll_en_o` is high, and both qualifiers are low.
- R7: In Sleep the stop-clock input is ignored. Only sleep release, a deep-sleep request or bus-clock loss can change the state.
- R8: In Sleep, a high `sleep_req_ni` returns the block to Stop-Grant with the Stop-Grant enables of R3. This wins over the other Sleep exits.
- R9: In Sleep, a low `deep_req_ni` or a low `bclk_ok_i` moves the block to Deep Sleep (code 3). In Deep Sleep every enable and qualifier is low.
- R10: Deep Sleep returns to Sleep only when `deep_req_ni` is high and `bclk_ok_i` is high. Otherwise it stays in Deep Sleep.
- R11: Asserting `rst_ni` in any state forces Normal at once, without waiting for a clock edge.
- R12: A state change shows at the outputs `SYNC_STAGES`+1 rising edges after the input edge that causes it, and not one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_req_ni | input | 1 | Stop-clock request, active low, asynchronous |
| sleep_req_ni | input | 1 | Sleep request, active low, asynchronous |
| deep_req_ni | input | 1 | Deep-sleep request, active low, asynchronous |
| bclk_ok_i | input | 1 | High while the bus clock is present, asynchronous |
| core_clk_en_o | output | 1 | Clock enable for the core execution units |
| bus_clk_en_o | output | 1 | Clock enable for the front-side-bus unit |
| intc_clk_en_o | output | 1 | Clock enable for the interrupt-controller unit |
| pll_en_o | output | 1 | PLL run enable |
| snoop_en_o | output | 1 | Bus snoops may be serviced |
| irq_en_o | output | 1 | Interrupts may be serviced |
| sg_ack_req_o | output | 1 | One-cycle request for a Stop-Grant acknowledge transaction |
| pstate_o | output | 2 | State code: 0 Normal, 1 Stop-Grant, 2 Sleep, 3 Deep Sleep |

## Verification
An input that changes at a falling edge reaches the state register on the third rising edge that follows: two synchronizer flops, then the state flop. The state code, enables and qualifiers are due at the falling edge after that third rising edge. The acknowledge pulse is due in the same cycle and must be low again one cycle later. For every stimulus, the driver queues three expected items: the old state one cycle before the due cycle, the new state in the due cycle, and the new state with the pulse cleared one cycle after. The monitor compares each item only at the falling edge of its own cycle. An early, late or stretched response therefore fails a named check. Reset is asynchronous, so it is checked a nanosecond after the reset pin falls, with no wait for an edge.

// File: rtl/pss_pkg.sv
package pss_pkg;

  // State codes. The numeric values are visible on pstate_o.
  typedef enum logic [1:0] {
    PS_NORMAL = 2'd0,
    PS_STOPGR = 2'd1,
    PS_SLEEP  = 2'd2,
    PS_DEEP   = 2'd3
  } pstate_e;

  // Synchronized requests, active high inside the block.
  typedef struct packed {
    logic stop;
    logic sleep;
    logic deep;
    logic bclk_ok;
  } req_t;

  // Decoded unit enables and qualifiers.
  typedef struct packed {
    logic core;
    logic bus;
    logic intc;
    logic pll;
    logic snoop;
    logic irq;
  } en_t;

  localparam int unsigned REQ_W = $bits(req_t);
  localparam int unsigned EN_W  = $bits(en_t);

endpackage

// File: rtl/pss_sync.sv
module pss_sync #(
  parameter int unsigned WIDTH     = 4,
  parameter int unsigned STAGES    = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= RST_VAL;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  req_t    req_i,
  output pstate_e state_o,
  output logic    ack_o
);

  pstate_e state_q, state_d;
  logic    ack_q, ack_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_NORMAL: begin
        if (req_i.stop) state_d = PS_STOPGR;
      end
      PS_STOPGR: begin
        if (!req_i.stop)      state_d = PS_NORMAL;
        else if (req_i.sleep) state_d = PS_SLEEP;
      end
      PS_SLEEP: begin
        if (!req_i.sleep)                       state_d = PS_STOPGR;
        else if (req_i.deep || !req_i.bclk_ok)  state_d = PS_DEEP;
      end
      PS_DEEP: begin
        if (!req_i.deep && req_i.bclk_ok) state_d = PS_SLEEP;
      end
      default: state_d = PS_NORMAL;
    endcase
  end

  assign ack_d = (state_q == PS_NORMAL) && (state_d == PS_STOPGR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_NORMAL;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
    end
  end

  assign state_o = state_q;
  assign ack_o   = ack_q;

endmodule

// File: rtl/pss_decode.sv
module pss_decode
  import pss_pkg::*;
(
  input  pstate_e state_i,
  output en_t     en_o
);

  always_comb begin
    en_o = '0;
    unique case (state_i)
      PS_NORMAL: en_o = '1;
      PS_STOPGR: begin
        en_o.bus   = 1'b1;
        en_o.intc  = 1'b1;
        en_o.pll   = 1'b1;
        en_o.snoop = 1'b1;
        en_o.irq   = 1'b1;
      end
      PS_SLEEP:  en_o.pll = 1'b1;
      PS_DEEP:   en_o = '0;
      default:   en_o = '1;
    endcase
  end

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pss_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_req_ni,
  input  logic       sleep_req_ni,
  input  logic       deep_req_ni,
  input  logic       bclk_ok_i,
  output logic       core_clk_en_o,
  output logic       bus_clk_en_o,
  output logic       intc_clk_en_o,
  output logic       pll_en_o,
  output logic       snoop_en_o,
  output logic       irq_en_o,
  output logic       sg_ack_req_o,
  output logic [1:0] pstate_o
);

  logic [REQ_W-1:0] raw_pins, sync_pins;
  req_t             req;
  pstate_e          state;
  en_t              en;

  assign raw_pins = {stop_req_ni, sleep_req_ni, deep_req_ni, bclk_ok_i};

  pss_sync #(
    .WIDTH   (REQ_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({REQ_W{1'b1}})
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_pins),
    .q_o    (sync_pins)
  );

  // Request pins are active low; bus-clock-present is active high.
  assign req.stop    = ~sync_pins[3];
  assign req.sleep   = ~sync_pins[2];
  assign req.deep    = ~sync_pins[1];
  assign req.bclk_ok =  sync_pins[0];

  pss_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .state_o (state),
    .ack_o   (sg_ack_req_o)
  );

  pss_decode u_dec (
    .state_i (state),
    .en_o    (en)
  );

  assign core_clk_en_o = en.core;
  assign bus_clk_en_o  = en.bus;
  assign intc_clk_en_o = en.intc;
  assign pll_en_o      = en.pll;
  assign snoop_en_o    = en.snoop;
  assign irq_en_o      = en.irq;
  assign pstate_o      = state;

endmodule

// File: rtl/pss_checker.sv
module pss_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       core_clk_en_o,
  input logic       bus_clk_en_o,
  input logic       intc_clk_en_o,
  input logic       pll_en_o,
  input logic       snoop_en_o,
  input logic       irq_en_o,
  input logic       sg_ack_req_o,
  input logic [1:0] pstate_o
);

  logic [5:0] en;
  assign en = {core_clk_en_o, bus_clk_en_o, intc_clk_en_o, pll_en_o, snoop_en_o, irq_en_o};

  assert_ack_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sg_ack_req_o |=> !sg_ack_req_o);

  assert_ack_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sg_ack_req_o |-> (pstate_o == 2'd1 && $past(pstate_o) == 2'd0));

  assert_stopgr_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstate_o == 2'd1 |-> en == 6'b011111);

  assert_normal_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstate_o == 2'd0 |-> en == 6'b111111);

  assert_normal_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstate_o == 2'd0 |=> (pstate_o == 2'd0 || pstate_o == 2'd1));

  assert_sleep_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstate_o == 2'd2 |-> en == 6'b000100);

  assert_sleep_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstate_o == 2'd2 |=> pstate_o != 2'd0);

  assert_deep_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstate_o == 2'd3 |-> en == 6'b000000);

  assert_deep_exit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pstate_o == 2'd3 |=> (pstate_o == 2'd3 || pstate_o == 2'd2));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_state_R11: assert (pstate_o == 2'd0 && en == 6'b111111 && !sg_ack_req_o);
    end
  end

endmodule

bind pwr_state_seq pss_checker u_pss_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .core_clk_en_o (core_clk_en_o),
  .bus_clk_en_o  (bus_clk_en_o),
  .intc_clk_en_o (intc_clk_en_o),
  .pll_en_o      (pll_en_o),
  .snoop_en_o    (snoop_en_o),
  .irq_en_o      (irq_en_o),
  .sg_ack_req_o  (sg_ack_req_o),
  .pstate_o      (pstate_o)
);

// File: tb/pwr_state_seq_bench.sv
module pwr_state_seq_bench;

  localparam int unsigned STAGES = 2;
  localparam int unsigned LAT    = STAGES + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stp_n = 1'b1, slp_n = 1'b1, dp_n = 1'b1, bok = 1'b1;
  logic core_en, bus_en, intc_en, pll_en, snp_en, irq_en, ack;
  logic [1:0] st;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  typedef struct {
    int         due;
    logic [1:0] st;
    logic       ack;
    string      tag;
  } item_t;

  item_t sbq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwr_state_seq #(.SYNC_STAGES(STAGES)) u_pwr_state_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .stop_req_ni(stp_n), .sleep_req_ni(slp_n), .deep_req_ni(dp_n), .bclk_ok_i(bok),
    .core_clk_en_o(core_en), .bus_clk_en_o(bus_en), .intc_clk_en_o(intc_en),
    .pll_en_o(pll_en), .snoop_en_o(snp_en), .irq_en_o(irq_en),
    .sg_ack_req_o(ack), .pstate_o(st)
  );

  // Expected enables per state code: {core,bus,intc,pll,snoop,irq}
  function automatic logic [5:0] exp_en(input logic [1:0] s);
    case (s)
      2'd0:    return 6'b111111;
      2'd1:    return 6'b011111;
      2'd2:    return 6'b000100;
      default: return 6'b000000;
    endcase
  endfunction

  function automatic logic [8:0] observed();
    return {st, core_en, bus_en, intc_en, pll_en, snp_en, irq_en, ack};
  endfunction

  task automatic check_now(input logic [1:0] s, input logic a, input string tag);
    logic [8:0] expv;
    expv = {s, exp_en(s), a};
    checks++;
    if (observed() !== expv) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, observed(), expv, cyc);
    end
  endtask

  // Monitor: compare every queued item in its due cycle.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      check_now(it.st, it.ack, it.tag);
    end
  end

  // Driver: apply pins, queue old/new/settled expectations.
  task automatic drive(input logic s_n, input logic l_n, input logic d_n, input logic b,
                       input logic [1:0] old_s, input logic [1:0] new_s,
                       input logic a, input string tag);
    int c;
    @(negedge clk);
    c = cyc;
    stp_n = s_n; slp_n = l_n; dp_n = d_n; bok = b;
    sbq.push_back('{due: c + LAT - 1, st: old_s, ack: 1'b0, tag: {tag, " R12 early"}});
    sbq.push_back('{due: c + LAT,     st: new_s, ack: a,    tag: tag});
    sbq.push_back('{due: c + LAT + 1, st: new_s, ack: 1'b0, tag: {tag, " settled"}});
    repeat (LAT + 3) @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now(2'd0, 1'b0, "R1 reset outputs");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5: sleep ignored in Normal
    drive(1, 0, 1, 1, 2'd0, 2'd0, 0, "R5 sleep in Normal ignored");
    drive(1, 1, 1, 1, 2'd0, 2'd0, 0, "R5 sleep released");
    // R2/R3: enter Stop-Grant with pulse
    drive(0, 1, 1, 1, 2'd0, 2'd1, 1, "R2 R3 enter Stop-Grant");
    // R4: leave, stop release wins over sleep
    drive(1, 0, 1, 1, 2'd1, 2'd0, 0, "R4 stop release beats sleep");
    drive(1, 1, 1, 1, 2'd0, 2'd0, 0, "R5 back to idle pins");
    drive(0, 1, 1, 1, 2'd0, 2'd1, 1, "R2 second entry");
    // R6: into Sleep
    drive(0, 0, 1, 1, 2'd1, 2'd2, 0, "R6 enter Sleep");
    // R7: stop-clock ignored in Sleep
    drive(1, 0, 1, 1, 2'd2, 2'd2, 0, "R7 stop release ignored in Sleep");
    drive(0, 0, 1, 1, 2'd2, 2'd2, 0, "R7 stop reassert ignored in Sleep");
    // R8: sleep release returns to Stop-Grant without pulse
    drive(0, 1, 1, 1, 2'd2, 2'd1, 0, "R8 R2 Sleep to Stop-Grant no pulse");
    drive(0, 0, 1, 1, 2'd1, 2'd2, 0, "R6 re-enter Sleep");
    // R9: deep request
    drive(0, 0, 0, 1, 2'd2, 2'd3, 0, "R9 deep request");
    // R10: exits need both conditions
    drive(0, 0, 0, 0, 2'd3, 2'd3, 0, "R10 clock lost stays Deep");
    drive(0, 0, 1, 0, 2'd3, 2'd3, 0, "R10 deep released clock absent");
    drive(0, 0, 1, 1, 2'd3, 2'd2, 0, "R10 Deep to Sleep");
    // R9: bus clock loss in Sleep
    drive(0, 0, 1, 0, 2'd2, 2'd3, 0, "R9 clock loss in Sleep");
    drive(0, 0, 1, 1, 2'd3, 2'd2, 0, "R10 clock back");

    // R11: asynchronous reset from Sleep
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check_now(2'd0, 1'b0, "R11 async reset from Sleep");
    stp_n = 1'b1; slp_n = 1'b1; dp_n = 1'b1; bok = 1'b1;
    repeat (3) @(negedge clk);
    check_now(2'd0, 1'b0, "R1 held in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_now(2'd0, 1'b0, "R1 idle after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule